// File: doc/BRIEF.md
# Command/Indication Channel Handler

This block terminates two command/indication slots of a time-division serial frame. Once per frame an upstream deframer hands it a 4-bit code for the primary channel and a 6-bit code for the auxiliary channel. The block keeps the last accepted code of each channel in a host-readable register. It sets a sticky change flag whenever an accepted code moves. The primary channel accepts a new code only after the same value has arrived in two frames in a row. This filters single-frame glitches on the line. The auxiliary channel accepts any change at once.

In the other direction the host writes one transmit code per channel. The block drives those codes on its outgoing slot pins without a break, so every frame carries them until the host writes a new value. A small synchronous register port gives access to both receive codes, both transmit codes, the status flags and an interrupt mask. One interrupt pin is the OR of the status flags that the mask does not block.

The frame input is a valid/ready stream whose ready is tied high. The block takes one frame sample in every cycle where `frm_valid` is high and never applies back-pressure. An upstream stage may therefore present frames back to back. It must not hold a frame expecting a stall. The transmit codes are level outputs with no handshake.

Top module: `ci_chan_ctrl`

## Requirements
- R1: After synchronous reset, the primary receive code reads 4'hF and the auxiliary receive code reads 6'h3F. The two transmit codes are 4'hF and 6'h3F. The status flags and the mask are 0, and `irq` is low.
- R2: Primary channel acceptance: when a code that differs from the accepted primary code is seen in two consecutive valid frames, the accepted code takes that value and status bit 0 is set. Both become visible in the cycle after the second frame.
- R3: A pending primary candidate is dropped when a valid frame carries a third value. The third value becomes the new candidate and needs a second matching frame of its own. A pending candidate is also dropped when a valid frame carries the already accepted code, and that frame sets no flag.
- R4: Auxiliary channel: any valid frame whose auxiliary code differs from the accepted one updates it and sets status bit 1, both visible in the next cycle.
- R5: Status bits (address 4: bit 0 primary, bit 1 auxiliary) are sticky. A cycle with `reg_rd` high at address 4 clears them after that cycle. A flag raised in the same cycle as the clearing read survives the read.
- R6: A write to address 2 (primary, wdata[3:0]) or to address 3 (auxiliary, wdata[5:0]) appears on the matching transmit output in the next cycle. The output holds that value in every later cycle until the next write to the same address.
- R7: `irq` equals the OR over the status bits whose mask bit is 0. The mask sits at address 5, bits [1:0], and a mask bit of 1 blocks the matching status bit.
- R8: Received codes are taken only in cycles with `frm_valid` high; code changes without it have no effect. `frm_ready` is always high.
- R9: Reads are combinational and zero-extended to 8 bits: address 0 gives the primary receive code, 1 the auxiliary receive code, 2 and 3 the transmit codes, 4 the status and 5 the mask. Other addresses read 0. Writes to addresses 0, 1 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Frame sample strobe, one per received frame |
| frm_ready | output | 1 | Always high: no back-pressure |
| frm_rx0 | input | 4 | Primary channel code of the current frame |
| frm_rx1 | input | 6 | Auxiliary channel code of the current frame |
| tx_code0 | output | 4 | Primary channel transmit code |
| tx_code1 | output | 6 | Auxiliary channel transmit code |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read strobe (clears status at address 4) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq | output | 1 | Combined unmasked change interrupt |

## Verification
The bound checker watches several rules in every cycle. The accepted codes change only in the cycle after a valid frame. The auxiliary code follows every valid frame. Flags stay set until a read clears them. Transmit codes move only after a write to their own address, and `irq` is low when no flag is set. The two-frame confirmation sequences cannot be reduced to one-cycle properties, so only the bench scenarios show them. These are a candidate replaced by a third value, a candidate cancelled by the accepted code, and a flag raised in the same cycle as a clearing read. Masking is also shown only there. The bench's behavioural model is compared with every output and with the read data in every cycle.

// File: rtl/ci_pkg.sv
package ci_pkg;
  parameter int unsigned W0 = 4;
  parameter int unsigned W1 = 6;
  parameter int unsigned DW = 8;
  parameter int unsigned AW = 3;
  parameter int unsigned NFLAG = 2;

  localparam logic [AW-1:0] A_RX0  = 3'd0;
  localparam logic [AW-1:0] A_RX1  = 3'd1;
  localparam logic [AW-1:0] A_TX0  = 3'd2;
  localparam logic [AW-1:0] A_TX1  = 3'd3;
  localparam logic [AW-1:0] A_STAT = 3'd4;
  localparam logic [AW-1:0] A_MASK = 3'd5;

  typedef enum logic [0:0] {CAND_NONE = 1'b0, CAND_HELD = 1'b1} cand_e;
endpackage

// File: rtl/ci_rx_confirm.sv
module ci_rx_confirm #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp,
  input  logic [W-1:0] code,
  output logic [W-1:0] acc,
  output logic         chg
);
  import ci_pkg::*;

  logic [W-1:0] cand_q;
  cand_e        st_q;
  logic         same_acc;
  logic         confirm;

  assign same_acc = (code == acc);
  assign confirm  = smp && !same_acc && (st_q == CAND_HELD) && (code == cand_q);
  assign chg      = confirm;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '1;
      cand_q <= '1;
      st_q   <= CAND_NONE;
    end else if (smp) begin
      if (same_acc) begin
        st_q <= CAND_NONE;
      end else if (confirm) begin
        acc  <= code;
        st_q <= CAND_NONE;
      end else begin
        cand_q <= code;
        st_q   <= CAND_HELD;
      end
    end
  end
endmodule

// File: rtl/ci_rx_direct.sv
module ci_rx_direct #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp,
  input  logic [W-1:0] code,
  output logic [W-1:0] acc,
  output logic         chg
);
  assign chg = smp && (code != acc);

  always_ff @(posedge clk) begin
    if (rst)      acc <= '1;
    else if (chg) acc <= code;
  end
endmodule

// File: rtl/ci_regs.sv
module ci_regs #(
  parameter int unsigned W0 = 4,
  parameter int unsigned W1 = 6,
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3,
  parameter int unsigned NF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [W0-1:0] rx0,
  input  logic [W1-1:0] rx1,
  input  logic [NF-1:0] evt,
  output logic [W0-1:0] tx0,
  output logic [W1-1:0] tx1,
  output logic [NF-1:0] stat,
  output logic [NF-1:0] mask,
  output logic          irq
);
  import ci_pkg::*;

  logic clr;
  assign clr = rd && (addr == A_STAT);

  genvar g;
  generate
    for (g = 0; g < NF; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)         stat[g] <= 1'b0;
        else if (evt[g]) stat[g] <= 1'b1;
        else if (clr)    stat[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tx0  <= '1;
      tx1  <= '1;
      mask <= '0;
    end else if (wr) begin
      case (addr)
        A_TX0:   tx0  <= wdata[W0-1:0];
        A_TX1:   tx1  <= wdata[W1-1:0];
        A_MASK:  mask <= wdata[NF-1:0];
        default: ;
      endcase
    end
  end

  assign irq = |(stat & ~mask);

  always_comb begin
    rdata = '0;
    case (addr)
      A_RX0:   rdata = {{(DW-W0){1'b0}}, rx0};
      A_RX1:   rdata = {{(DW-W1){1'b0}}, rx1};
      A_TX0:   rdata = {{(DW-W0){1'b0}}, tx0};
      A_TX1:   rdata = {{(DW-W1){1'b0}}, tx1};
      A_STAT:  rdata = {{(DW-NF){1'b0}}, stat};
      A_MASK:  rdata = {{(DW-NF){1'b0}}, mask};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ci_chan_ctrl.sv
module ci_chan_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       frm_valid,
  output logic       frm_ready,
  input  logic [3:0] frm_rx0,
  input  logic [5:0] frm_rx1,
  output logic [3:0] tx_code0,
  output logic [5:0] tx_code1,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  import ci_pkg::*;

  logic [W0-1:0]    acc0;
  logic [W1-1:0]    acc1;
  logic [NFLAG-1:0] evt;
  logic [NFLAG-1:0] stat;
  logic [NFLAG-1:0] mask;
  logic             smp;

  assign frm_ready = 1'b1;
  assign smp       = frm_valid && frm_ready;

  ci_rx_confirm #(.W(W0)) u_rx0 (
    .clk(clk), .rst(rst), .smp(smp), .code(frm_rx0), .acc(acc0), .chg(evt[0])
  );

  ci_rx_direct #(.W(W1)) u_rx1 (
    .clk(clk), .rst(rst), .smp(smp), .code(frm_rx1), .acc(acc1), .chg(evt[1])
  );

  ci_regs #(.W0(W0), .W1(W1), .DW(DW), .AW(AW), .NF(NFLAG)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .rdata(reg_rdata), .rx0(acc0), .rx1(acc1), .evt(evt),
    .tx0(tx_code0), .tx1(tx_code1), .stat(stat), .mask(mask), .irq(irq)
  );
endmodule

// File: rtl/ci_chan_ctrl_chk.sv
module ci_chan_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       frm_valid,
  input logic [3:0] frm_rx0,
  input logic [5:0] frm_rx1,
  input logic [3:0] acc0,
  input logic [5:0] acc1,
  input logic [1:0] stat,
  input logic [3:0] tx_code0,
  input logic [5:0] tx_code1,
  input logic [2:0] reg_addr,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       irq
);
  p_rx0_after_frame_r2: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> $stable(acc0));

  p_rx0_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_rx0 != acc0) |=> (acc0 == $past(acc0)) || stat[0]);

  p_rx1_follow_r4: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> acc1 == $past(frm_rx1));

  p_rx1_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_rx1 != acc1) |=> stat[1]);

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (stat[0] && !(reg_rd && reg_addr == 3'd4)) |=> stat[0]);

  p_tx0_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == 3'd2) |=> $stable(tx_code0));

  p_tx1_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == 3'd3) |=> $stable(tx_code1));

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (stat == 2'b00) |-> !irq);

  p_no_sample_r8: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> $stable(acc1));
endmodule

bind ci_chan_ctrl ci_chan_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_rx0(frm_rx0),
  .frm_rx1(frm_rx1), .acc0(acc0), .acc1(acc1), .stat(stat),
  .tx_code0(tx_code0), .tx_code1(tx_code1), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .irq(irq)
);

// File: tb/sim_ci_chan_ctrl.sv
module sim_ci_chan_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm_valid = 1'b0;
  logic       frm_ready;
  logic [3:0] frm_rx0 = 4'hF;
  logic [5:0] frm_rx1 = 6'h3F;
  logic [3:0] tx_code0;
  logic [5:0] tx_code1;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  int m_acc0, m_cand, m_pend, m_acc1, m_tx0, m_tx1, m_mask, m_stat;

  always #4 clk = ~clk;

  ci_chan_ctrl u0 (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_rx0(frm_rx0), .frm_rx1(frm_rx1), .tx_code0(tx_code0),
    .tx_code1(tx_code1), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    int ev;
    int c0, c1;
    if (rst) begin
      m_acc0 = 15; m_cand = 0; m_pend = 0; m_acc1 = 63;
      m_tx0 = 15; m_tx1 = 63; m_mask = 0; m_stat = 0;
    end else begin
      ev = 0;
      c0 = int'(frm_rx0);
      c1 = int'(frm_rx1);
      if (frm_valid) begin
        if (c0 == m_acc0) m_pend = 0;
        else if (m_pend != 0 && c0 == m_cand) begin
          m_acc0 = c0; m_pend = 0; ev = ev | 1;
        end else begin
          m_cand = c0; m_pend = 1;
        end
        if (c1 != m_acc1) begin
          m_acc1 = c1; ev = ev | 2;
        end
      end
      if (reg_rd && reg_addr == 3'd4) m_stat = 0;
      m_stat = m_stat | ev;
      if (reg_wr) begin
        if (reg_addr == 3'd2) m_tx0 = int'(reg_wdata) % 16;
        if (reg_addr == 3'd3) m_tx1 = int'(reg_wdata) % 64;
        if (reg_addr == 3'd5) m_mask = int'(reg_wdata) % 4;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int m_read(input int a);
    case (a)
      0: return m_acc0;
      1: return m_acc1;
      2: return m_tx0;
      3: return m_tx1;
      4: return m_stat;
      5: return m_mask;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(input int a);
    case (a)
      0: return "R2 rx0";
      1: return "R4 rx1";
      2, 3: return "R6 tx";
      4: return "R5 status";
      5: return "R7 mask";
      default: return "R9 unmapped";
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
    cyc++;
    chk("R6 tx_code0", int'(tx_code0), m_tx0);
    chk("R6 tx_code1", int'(tx_code1), m_tx1);
    chk("R7 irq", int'(irq), ((m_stat & ~m_mask) & 3) != 0 ? 1 : 0);
    chk("R8 frm_ready", int'(frm_ready), 1);
    chk(rd_tag(int'(reg_addr)), int'(reg_rdata), m_read(int'(reg_addr)));
  endtask

  task automatic idle();
    frm_valid = 0; reg_wr = 0; reg_rd = 0;
    tick();
  endtask

  task automatic frame(input logic [3:0] a, input logic [5:0] b);
    frm_valid = 1; frm_rx0 = a; frm_rx1 = b;
    tick();
    frm_valid = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick();
    reg_wr = 0;
  endtask

  task automatic peek(input logic [2:0] a, input bit clr);
    reg_addr = a; reg_rd = clr;
    tick();
    reg_rd = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst = 0;
    // R1 reset state via every address
    for (int a = 0; a < 8; a++) peek(3'(a), 0);
    reg_addr = 3'd0; tick();
    chk("R1 rx0 reset", int'(reg_rdata), 15);
    chk("R1 irq reset", int'(irq), 0);
    // R9 writes to read-only addresses ignored
    wr(3'd0, 8'h03); wr(3'd1, 8'h01); wr(3'd4, 8'h03);
    peek(3'd0, 0);
    chk("R9 rx0 write ignored", int'(reg_rdata), 15);
    // R6 transmit codes, truncation
    wr(3'd2, 8'hA5); wr(3'd3, 8'h12);
    idle(); idle();
    chk("R6 tx0 held", int'(tx_code0), 5);
    chk("R6 tx1 held", int'(tx_code1), 8'h12);
    // R2 two-frame acceptance
    peek(3'd0, 0);
    frame(4'h3, 6'h3F);
    chk("R2 one frame no accept", int'(reg_rdata), 15);
    frame(4'h3, 6'h3F);
    chk("R2 accepted", int'(reg_rdata), 3);
    chk("R2 irq", int'(irq), 1);
    peek(3'd4, 1);
    idle();
    chk("R5 cleared by read", int'(reg_rdata), 0);
    // R3 third value restarts confirmation
    reg_addr = 3'd0;
    frame(4'h7, 6'h3F); frame(4'h9, 6'h3F);
    chk("R3 no accept after switch", int'(reg_rdata), 3);
    frame(4'h9, 6'h3F);
    chk("R3 third value accepted", int'(reg_rdata), 9);
    // R3 accepted code cancels pending
    frame(4'h7, 6'h3F); frame(4'h9, 6'h3F); frame(4'h7, 6'h3F);
    chk("R3 cancel by accepted", int'(reg_rdata), 9);
    frame(4'h7, 6'h3F);
    chk("R3 accept after cancel", int'(reg_rdata), 7);
    // R8 no sampling without strobe
    frm_rx0 = 4'h1; frm_rx1 = 6'h01;
    idle(); idle(); idle();
    chk("R8 rx0 unchanged", int'(reg_rdata), 7);
    peek(3'd4, 1); idle();
    // R4 auxiliary single frame
    reg_addr = 3'd1;
    frame(4'h7, 6'h2A);
    chk("R4 rx1 follows", int'(reg_rdata), 8'h2A);
    reg_addr = 3'd4; tick();
    chk("R4 flag", int'(reg_rdata), 2);
    // R5 flag set in same cycle as clearing read survives
    reg_rd = 1; frm_valid = 1; frm_rx1 = 6'h15;
    tick();
    frm_valid = 0; reg_rd = 0;
    tick();
    chk("R5 set wins over clear", int'(reg_rdata), 2);
    // R7 masking
    wr(3'd5, 8'h02);
    chk("R7 masked irq", int'(irq), 0);
    frame(4'h4, 6'h15); frame(4'h4, 6'h15);
    chk("R7 unmasked bit0 irq", int'(irq), 1);
    wr(3'd5, 8'h03);
    chk("R7 all masked", int'(irq), 0);
    peek(3'd4, 1); idle();
    chk("R5 read clears", int'(reg_rdata), 0);
    // back-to-back frames on both channels
    for (int i = 0; i < 20; i++) frame(4'(i / 2), 6'(i * 5));
    wr(3'd5, 8'h00);
    for (int i = 0; i < 10; i++) idle();
    finish_run();
  end
endmodule